// File: doc/BRIEF.md
# Latency-Hiding Interleaved Matrix Multiplier

This block forms the product C = A x B of two 16x16 signed integer matrices held in on-chip scratch memories. Every element of C is an inner product of 16 terms. The running sum passes through an adder pipeline with a seven-cycle latency, so a single sum cannot absorb one new term per cycle. The block therefore keeps eight inner products of one row in flight at once (a group of eight adjacent columns) and feeds their terms to the adder in rotation. A term then enters the pipeline every cycle, and no partial sum returns to the adder before its previous addition has completed.

The work is split into three parts. A loop controller steps the row, column-group, k and slot counters. An access part forms the A and B read addresses and the C write address. A compute part holds one registered multiplier, the seven-stage adder and one partial-sum register per slot. Each term carries a tag through the pipeline that names its destination row, column and slot.

A pulse on `start` while the block is idle launches a full product. The block then issues one read pair per cycle for 4096 cycles and writes each C element once. It raises `done` for one cycle after the last element has been written. The scratch memories return read data one cycle after the address and always accept a write, so the memory ports have no handshake and no back-pressure.

Top module: `ilv_matmul`

## Requirements
- R1: During and directly after reset, `busy`, `done`, `a_rd_en`, `b_rd_en` and `c_wr_en` are all low.
- R2: A `start` sampled high while idle makes `busy` high from the next cycle on, and the first read pair is presented in that same next cycle.
- R3: Each written value equals the signed sum over k = 0..15 of A[i][k]·B[k][j], computed without overflow in a result width of 2·OP_W+4 bits.
- R4: Reads follow the interleaved order: for each row i, each group of eight columns and each k, the columns of the group are read in ascending order before k advances. The A address is i·16+k and the B address is k·16+j, with the major index in the upper four bits.
- R5: `a_rd_en` and `b_rd_en` are high together on exactly 4096 consecutive cycles per run, with no gap.
- R6: Every C element is written exactly once per run, at address i·16+j. Writes arrive in ascending address order 0..255.
- R7: An element is written nine cycles after the read of its k = 15 term (one cycle memory, one cycle multiplier, seven cycles adder). The first write therefore comes 130 cycles after `start` is sampled.
- R8: A `start` pulse while `busy` is high is ignored: the read order, the read count and the write count are unchanged.
- R9: `done` is high for exactly one cycle, in the cycle after the write to address 255. `busy` is low in that cycle, and a later `start` begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, taken only while idle |
| busy | output | 1 | High from launch until done |
| done | output | 1 | One-cycle completion pulse |
| a_rd_en | output | 1 | Read strobe for the A memory |
| a_rd_addr | output | 8 | A address, row in upper half, k in lower half |
| a_rd_data | input | OP_W | A element, valid one cycle after the address |
| b_rd_en | output | 1 | Read strobe for the B memory |
| b_rd_addr | output | 8 | B address, k in upper half, column in lower half |
| b_rd_data | input | OP_W | B element, valid one cycle after the address |
| c_wr_en | output | 1 | Write strobe for the C memory |
| c_wr_addr | output | 8 | C address, row in upper half, column in lower half |
| c_wr_data | output | 2·OP_W+4 | Signed inner-product result |

## Verification
The product is exercised with four operand patterns. Full-range random matrices test the general arithmetic. Both matrices filled with the most negative value test sign extension and the widest result. An identity A against a random B would expose swapped row and column indices or a mixed-up slot. A ramp A against an identity B gives every element a unique value, so a write to the wrong address or a sum leaking between slots shows up at once. One run receives a stray `start` in mid-flight, and the cycle-exact read order, the write order and the write timing are compared against counters derived from the loop order.

// File: rtl/ilv_mm_pkg.sv
package ilv_mm_pkg;
  localparam int DIM    = 16;
  localparam int GROUP  = 8;
  localparam int IDX_W  = $clog2(DIM);
  localparam int ADDR_W = 2 * IDX_W;
  localparam int SLOT_W = $clog2(GROUP);
  localparam int NGRP   = DIM / GROUP;
  localparam int GRP_W  = (NGRP > 1) ? $clog2(NGRP) : 1;

  typedef struct packed {
    logic [IDX_W-1:0]  row;
    logic [IDX_W-1:0]  col;
    logic [SLOT_W-1:0] slot;
    logic              first;
    logic              last;
  } term_tag_t;
endpackage

// File: rtl/ilv_mm_loop.sv
module ilv_mm_loop
  import ilv_mm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             finish,
  output logic             busy,
  output logic             issue,
  output logic [IDX_W-1:0] k_idx,
  output term_tag_t        tag
);
  logic              busy_q, run_q;
  logic [IDX_W-1:0]  row_q, k_q;
  logic [GRP_W-1:0]  grp_q;
  logic [SLOT_W-1:0] slot_q;
  logic wrap_slot, wrap_k, wrap_grp, wrap_row;

  assign wrap_slot = (slot_q == SLOT_W'(GROUP - 1));
  assign wrap_k    = (k_q == IDX_W'(DIM - 1));
  assign wrap_grp  = (grp_q == GRP_W'(NGRP - 1));
  assign wrap_row  = (row_q == IDX_W'(DIM - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      run_q  <= 1'b0;
      row_q  <= '0;
      k_q    <= '0;
      grp_q  <= '0;
      slot_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        run_q  <= 1'b1;
        row_q  <= '0;
        k_q    <= '0;
        grp_q  <= '0;
        slot_q <= '0;
      end
    end else begin
      if (run_q) begin
        slot_q <= slot_q + 1'b1;
        if (wrap_slot) begin
          k_q <= k_q + 1'b1;
          if (wrap_k) begin
            grp_q <= wrap_grp ? '0 : grp_q + 1'b1;
            if (wrap_grp) begin
              row_q <= row_q + 1'b1;
              if (wrap_row) run_q <= 1'b0;
            end
          end
        end
      end
      if (finish) busy_q <= 1'b0;
    end
  end

  assign busy      = busy_q;
  assign issue     = run_q;
  assign k_idx     = k_q;
  assign tag.row   = row_q;
  assign tag.col   = IDX_W'({grp_q, slot_q});
  assign tag.slot  = slot_q;
  assign tag.first = (k_q == '0);
  assign tag.last  = wrap_k;
endmodule

// File: rtl/ilv_mm_addr.sv
module ilv_mm_addr
  import ilv_mm_pkg::*;
(
  input  logic              issue,
  input  logic [IDX_W-1:0]  rd_row,
  input  logic [IDX_W-1:0]  rd_col,
  input  logic [IDX_W-1:0]  rd_k,
  input  logic [IDX_W-1:0]  wr_row,
  input  logic [IDX_W-1:0]  wr_col,
  output logic              a_en,
  output logic [ADDR_W-1:0] a_addr,
  output logic              b_en,
  output logic [ADDR_W-1:0] b_addr,
  output logic [ADDR_W-1:0] c_addr
);
  // A is walked along its row, B down its column, C row-major.
  assign a_en   = issue;
  assign b_en   = issue;
  assign a_addr = {rd_row, rd_k};
  assign b_addr = {rd_k, rd_col};
  assign c_addr = {wr_row, wr_col};
endmodule

// File: rtl/ilv_mm_mac.sv
module ilv_mm_mac
  import ilv_mm_pkg::*;
#(
  parameter int OP_W    = 16,
  parameter int ADD_LAT = 7,
  parameter int ACC_W   = 2 * OP_W + IDX_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    issue,
  input  term_tag_t               tag_in,
  input  logic [OP_W-1:0]         a_data,
  input  logic [OP_W-1:0]         b_data,
  output logic                    wr_en,
  output logic [IDX_W-1:0]        wr_row,
  output logic [IDX_W-1:0]        wr_col,
  output logic signed [ACC_W-1:0] wr_sum
);
  // stage 1: tag waits for memory data
  logic      rd_vld_q;
  term_tag_t rd_tag_q;
  // stage 2: registered product
  logic                    mul_vld_q;
  term_tag_t               mul_tag_q;
  logic signed [ACC_W-1:0] prod_q;
  logic signed [2*OP_W-1:0] prod_w;
  // adder pipeline and per-slot partial sums
  logic                    pipe_vld [ADD_LAT];
  term_tag_t               pipe_tag [ADD_LAT];
  logic signed [ACC_W-1:0] pipe_sum [ADD_LAT];
  logic signed [ACC_W-1:0] psum     [GROUP];
  logic signed [ACC_W-1:0] partial, entry_sum;

  assign prod_w = $signed(a_data) * $signed(b_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q  <= 1'b0;
      mul_vld_q <= 1'b0;
    end else begin
      rd_vld_q  <= issue;
      mul_vld_q <= rd_vld_q;
    end
  end

  always_ff @(posedge clk) begin
    rd_tag_q  <= tag_in;
    mul_tag_q <= rd_tag_q;
    prod_q    <= ACC_W'(prod_w);
  end

  assign partial   = mul_tag_q.first ? '0 : psum[mul_tag_q.slot];
  assign entry_sum = prod_q + partial;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < ADD_LAT; s++) pipe_vld[s] <= 1'b0;
    end else begin
      pipe_vld[0] <= mul_vld_q;
      for (int s = 1; s < ADD_LAT; s++) pipe_vld[s] <= pipe_vld[s-1];
    end
  end

  always_ff @(posedge clk) begin
    pipe_tag[0] <= mul_tag_q;
    pipe_sum[0] <= entry_sum;
    for (int s = 1; s < ADD_LAT; s++) begin
      pipe_tag[s] <= pipe_tag[s-1];
      pipe_sum[s] <= pipe_sum[s-1];
    end
    if (pipe_vld[ADD_LAT-1]) psum[pipe_tag[ADD_LAT-1].slot] <= pipe_sum[ADD_LAT-1];
  end

  assign wr_en  = pipe_vld[ADD_LAT-1] && pipe_tag[ADD_LAT-1].last;
  assign wr_row = pipe_tag[ADD_LAT-1].row;
  assign wr_col = pipe_tag[ADD_LAT-1].col;
  assign wr_sum = pipe_sum[ADD_LAT-1];
endmodule

// File: rtl/ilv_matmul.sv
module ilv_matmul
  import ilv_mm_pkg::*;
#(
  parameter int OP_W    = 16,
  parameter int ADD_LAT = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  output logic                        busy,
  output logic                        done,
  output logic                        a_rd_en,
  output logic [2*IDX_W-1:0]          a_rd_addr,
  input  logic [OP_W-1:0]             a_rd_data,
  output logic                        b_rd_en,
  output logic [2*IDX_W-1:0]          b_rd_addr,
  input  logic [OP_W-1:0]             b_rd_data,
  output logic                        c_wr_en,
  output logic [2*IDX_W-1:0]          c_wr_addr,
  output logic [2*OP_W+IDX_W-1:0]     c_wr_data
);
  localparam int ACC_W = 2 * OP_W + IDX_W;

  logic             issue, finish, done_q;
  logic [IDX_W-1:0] k_idx, wr_row, wr_col;
  term_tag_t        tag;
  logic signed [ACC_W-1:0] wr_sum;

  assign finish = c_wr_en && (c_wr_addr == '1);

  ilv_mm_loop loop_i (
    .clk(clk), .rst_n(rst_n), .start(start), .finish(finish),
    .busy(busy), .issue(issue), .k_idx(k_idx), .tag(tag)
  );

  ilv_mm_addr addr_i (
    .issue(issue), .rd_row(tag.row), .rd_col(tag.col), .rd_k(k_idx),
    .wr_row(wr_row), .wr_col(wr_col),
    .a_en(a_rd_en), .a_addr(a_rd_addr), .b_en(b_rd_en), .b_addr(b_rd_addr),
    .c_addr(c_wr_addr)
  );

  ilv_mm_mac #(.OP_W(OP_W), .ADD_LAT(ADD_LAT), .ACC_W(ACC_W)) mac_i (
    .clk(clk), .rst_n(rst_n), .issue(issue), .tag_in(tag),
    .a_data(a_rd_data), .b_data(b_rd_data),
    .wr_en(c_wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_sum(wr_sum)
  );

  assign c_wr_data = wr_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= finish;
  end
  assign done = done_q;
endmodule

// File: rtl/ilv_matmul_chk.sv
module ilv_matmul_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          a_rd_en,
  input logic [AW-1:0] a_rd_addr,
  input logic          b_rd_en,
  input logic [AW-1:0] b_rd_addr,
  input logic          c_wr_en,
  input logic [AW-1:0] c_wr_addr
);
  localparam int HW = AW / 2;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!a_rd_en && !b_rd_en && !c_wr_en));

  // R5
  rd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_rd_en |-> (b_rd_en && a_rd_addr[HW-1:0] == b_rd_addr[AW-1:HW]));

  // R4
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rd_en && b_rd_addr[2:0] != 3'd0) |->
      ($past(a_rd_en) && b_rd_addr == $past(b_rd_addr) + 1'b1));

  // R6
  wr_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr_en |-> busy);

  // R9
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(c_wr_en) && $past(c_wr_addr) == '1 && !busy));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind ilv_matmul ilv_matmul_chk #(.AW(2 * ilv_mm_pkg::IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .a_rd_en(a_rd_en), .a_rd_addr(a_rd_addr),
  .b_rd_en(b_rd_en), .b_rd_addr(b_rd_addr),
  .c_wr_en(c_wr_en), .c_wr_addr(c_wr_addr)
);

// File: tb/ilv_matmul_tb_top.sv
module ilv_matmul_tb_top;
  localparam int CLK_PER = 10;
  localparam int OP_W    = 16;
  localparam int ACC_W   = 2 * OP_W + 4;
  localparam int WDOG    = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, a_rd_en, b_rd_en, c_wr_en;
  logic [7:0] a_rd_addr, b_rd_addr, c_wr_addr;
  logic [OP_W-1:0] a_rd_data, b_rd_data;
  logic [ACC_W-1:0] c_wr_data;

  logic signed [OP_W-1:0] mem_a [256];
  logic signed [OP_W-1:0] mem_b [256];

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int rd_idx, wr_cnt, first_rd, last_rd, first_wr, last_wr, done_cnt, done_cyc;
  bit written [256];
  bit mon_on = 1'b0;
  bit done_busy_seen;

  always #(CLK_PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (a_rd_en) a_rd_data <= mem_a[a_rd_addr];
    if (b_rd_en) b_rd_data <= mem_b[b_rd_addr];
  end

  ilv_matmul #(.OP_W(OP_W), .ADD_LAT(7)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .a_rd_en(a_rd_en), .a_rd_addr(a_rd_addr), .a_rd_data(a_rd_data),
    .b_rd_en(b_rd_en), .b_rd_addr(b_rd_addr), .b_rd_data(b_rd_data),
    .c_wr_en(c_wr_en), .c_wr_addr(c_wr_addr), .c_wr_data(c_wr_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [ACC_W-1:0] ref_c(input int i, input int j);
    longint s = 0;
    for (int k = 0; k < 16; k++) s += longint'(mem_a[i*16+k]) * longint'(mem_b[k*16+j]);
    return ACC_W'(s);
  endfunction

  // Observer, sampled on the falling edge.
  always @(negedge clk) begin
    if (mon_on) begin
      if (a_rd_en || b_rd_en) begin
        int s, k, g, i, ea, eb;
        s = rd_idx % 8; k = (rd_idx / 8) % 16; g = (rd_idx / 128) % 2; i = rd_idx / 256;
        ea = i * 16 + k; eb = k * 16 + g * 8 + s;
        // R5: both strobes together
        chk(a_rd_en && b_rd_en, "R5", "read strobes paired", b_rd_en, a_rd_en);
        // R4 / R8: interleaved order, unaffected by a stray start
        chk(a_rd_addr == 8'(ea), "R4", "A read address", a_rd_addr, ea);
        chk(b_rd_addr == 8'(eb), "R4", "B read address", b_rd_addr, eb);
        if (rd_idx == 0) first_rd = cyc;
        last_rd = cyc;
        rd_idx++;
      end
      if (c_wr_en) begin
        logic [ACC_W-1:0] e;
        e = ref_c(c_wr_addr / 16, c_wr_addr % 16);
        // R3
        chk(c_wr_data == e, "R3", "C element value", longint'($signed(c_wr_data)), longint'($signed(e)));
        // R6: ascending order, written once
        chk(c_wr_addr == 8'(wr_cnt), "R6", "C write order", c_wr_addr, wr_cnt);
        chk(!written[c_wr_addr], "R6", "C element written twice", c_wr_addr, -1);
        written[c_wr_addr] = 1'b1;
        if (wr_cnt == 0) first_wr = cyc;
        if (c_wr_addr == 8'd255) last_wr = cyc;
        wr_cnt++;
      end
      if (done) begin
        done_cnt++;
        done_cyc = cyc;
        done_busy_seen = busy;
      end
    end
  end

  task automatic run_mat(input string name, input bit stray_start);
    int t0;
    rd_idx = 0; wr_cnt = 0; done_cnt = 0; first_rd = -1; last_rd = -1;
    first_wr = -1; last_wr = -1; done_cyc = -1; done_busy_seen = 1'b0;
    for (int n = 0; n < 256; n++) written[n] = 1'b0;
    mon_on = 1'b1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t0 = cyc - 1;
    // R2: busy rises the cycle after start is sampled
    chk(busy == 1'b1, "R2", {name, " busy after start"}, busy, 1);
    if (stray_start) begin
      repeat (1000) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R8: still running after the stray start
      chk(busy == 1'b1, "R8", {name, " busy after stray start"}, busy, 1);
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (4) @(negedge clk);
    mon_on = 1'b0;
    // R2 / R5
    chk(first_rd == t0 + 1, "R2", {name, " first read cycle"}, first_rd - t0, 1);
    chk(rd_idx == 4096, "R5", {name, " read count"}, rd_idx, 4096);
    chk(last_rd - first_rd == 4095, "R5", {name, " read span"}, last_rd - first_rd, 4095);
    // R6 / R8
    chk(wr_cnt == 256, "R6", {name, " write count"}, wr_cnt, 256);
    // R7
    chk(first_wr == t0 + 130, "R7", {name, " first write delay"}, first_wr - t0, 130);
    chk(last_wr == last_rd + 9, "R7", {name, " last write delay"}, last_wr - last_rd, 9);
    // R9
    chk(done_cnt == 1, "R9", {name, " done pulse count"}, done_cnt, 1);
    chk(done_cyc == last_wr + 1, "R9", {name, " done timing"}, done_cyc - last_wr, 1);
    chk(!done_busy_seen && !busy, "R9", {name, " busy low at done"}, done_busy_seen, 0);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", WDOG, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: idle state during reset
    chk(!busy && !done && !a_rd_en && !b_rd_en && !c_wr_en, "R1", "outputs during reset",
        {busy, done, a_rd_en, b_rd_en, c_wr_en}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: idle state after reset
    chk(!busy && !done && !a_rd_en && !c_wr_en, "R1", "outputs after reset",
        {busy, done, a_rd_en, c_wr_en}, 0);

    for (int n = 0; n < 256; n++) begin
      mem_a[n] = OP_W'($urandom);
      mem_b[n] = OP_W'($urandom);
    end
    run_mat("random", 1'b1);

    for (int n = 0; n < 256; n++) begin
      mem_a[n] = 16'sh8000;
      mem_b[n] = 16'sh8000;
    end
    run_mat("most-negative", 1'b0);

    for (int n = 0; n < 256; n++) begin
      mem_a[n] = (n / 16 == n % 16) ? 16'sd1 : 16'sd0;
      mem_b[n] = OP_W'($urandom);
    end
    run_mat("identity-A", 1'b0);

    for (int n = 0; n < 256; n++) begin
      mem_a[n] = OP_W'(n * 97 - 9000);
      mem_b[n] = (n / 16 == n % 16) ? 16'sd1 : 16'sd0;
    end
    run_mat("ramp-A", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule